// File: doc/BRIEF.md
# Register-Operand ALU with Zero and Carry Flags

This block is the arithmetic and logic stage of a small programmable state machine. Each issued operation carries a 4-bit opcode, a first operand taken from the destination register and two candidate second operands: one read from a second register and one fetched from a constant table. The block picks the second operand, computes the result and raises a write strobe so that the register file can store the result back into the destination register.

The block holds the zero and carry flags. Add and subtract always fold the stored carry into the result, which lets a program chain multi-word arithmetic. The logical operations force carry to zero, so ORing a register with itself is a cheap way to clear it. A load copies the second operand and leaves both flags alone. Opcodes that belong to other units (shift, jump and port codes) produce no write and do not change the flags. The data width is a parameter.

The result and the write strobe are combinational from the inputs. The flags change on the rising clock edge that ends a valid operation.

Top module: `flag_alu`

## Requirements
- R1: While rstN is low, and right after it rises, zeroFlag and carryFlag are both 0.
- R2: Opcode bit 3 selects the second operand: 1 takes regB and 0 takes constB.
- R3: Opcode bits 2:0 = 101 is add. The result is regA + B + carryFlag, and the new carry is the carry out of the most significant bit.
- R4: Opcode bits 2:0 = 100 is subtract. The result is regA - B - carryFlag, and the new carry is 1 when this borrows (the true difference is negative).
- R5: Opcode bits 2:0 = 000, 001 and 010 are OR, AND and XOR of regA with B. Each of them clears carry.
- R6: Opcode bits 2:0 = 011 is load. The result is B, wrEn is high, and neither flag changes.
- R7: After add, subtract, OR, AND or XOR, zeroFlag is 1 exactly when the data-width result was all zeros.
- R8: Opcodes with bits 2:1 = 11 are not ALU operations. For these, wrEn stays low and both flags keep their values.
- R9: When opValid is low, wrEn is low and both flags keep their values.
- R10: The result and wrEn follow the inputs in the same cycle. The flags take their new values on the rising clock edge at which the valid operation is presented, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the flags |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code (the upper four bits of the instruction word) |
| regA | input | DATA_W | First operand, from the destination register |
| regB | input | DATA_W | Second operand from a register |
| constB | input | DATA_W | Second operand from the constant table |
| result | output | DATA_W | Value to write back to the destination register |
| wrEn | output | 1 | The destination register should take the result |
| zeroFlag | output | 1 | Stored zero flag |
| carryFlag | output | 1 | Stored carry/borrow flag, also used as carry-in |

## Verification
The checker assumes that opValid and opCode are stable and known through each clock cycle. The bench therefore changes them only on the falling edge. The zero-flag property compares against the result of the previous cycle, which is only meaningful if the operands do not move between the sampled edge and the flag update. The bench holds every operand for the whole cycle in which it is applied. Opcodes outside the ALU set are assumed to be legal traffic that the block must ignore, and the vector table mixes them among real operations so that the hold properties are exercised while the flags are set.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic       useReg;    // second operand from register
    logic       arith;     // add/subtract class
    logic       addSel;    // 1 add, 0 subtract
    logic [1:0] logicSel;  // 00 or, 01 and, 10 xor, 11 load
    logic       commit;    // result is written back
    logic       flagUpd;   // flags take new values
  } alu_strobe_t;

  localparam logic [1:0] LOGIC_OR  = 2'b00;
  localparam logic [1:0] LOGIC_AND = 2'b01;
  localparam logic [1:0] LOGIC_XOR = 2'b10;
  localparam logic [1:0] LOGIC_LD  = 2'b11;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic        opValid,
  input  logic [3:0]  opCode,
  output alu_strobe_t strobe
);

  logic isForeign;
  logic isLoad;

  // Bits 2:1 both set mark shift, jump and port codes
  assign isForeign = opCode[2] & opCode[1];
  assign isLoad    = ~opCode[2] & (opCode[1:0] == LOGIC_LD);

  always_comb begin
    strobe          = '0;
    strobe.useReg   = opCode[3];
    strobe.arith    = opCode[2];
    strobe.addSel   = opCode[0];
    strobe.logicSel = opCode[1:0];
    strobe.commit   = opValid & ~isForeign;
    strobe.flagUpd  = opValid & ~isForeign & ~isLoad;
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_strobe_t        strobe,
  input  logic [DATA_W-1:0]  regA,
  input  logic [DATA_W-1:0]  regB,
  input  logic [DATA_W-1:0]  constB,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  result,
  output logic               nextZero,
  output logic               nextCarry
);

  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] operandB;
  logic [EXT_W-1:0]  extA;
  logic [EXT_W-1:0]  extB;
  logic [EXT_W-1:0]  extC;
  logic [EXT_W-1:0]  arithOut;
  logic [DATA_W-1:0] logicOut;

  assign operandB = strobe.useReg ? regB : constB;
  assign extA     = {1'b0, regA};
  assign extB     = {1'b0, operandB};
  assign extC     = {{DATA_W{1'b0}}, carryIn};

  // One extra bit holds carry-out on add and borrow on subtract
  always_comb begin
    if (strobe.addSel) arithOut = extA + extB + extC;
    else               arithOut = extA - extB - extC;
  end

  always_comb begin
    unique case (strobe.logicSel)
      LOGIC_OR:  logicOut = regA | operandB;
      LOGIC_AND: logicOut = regA & operandB;
      LOGIC_XOR: logicOut = regA ^ operandB;
      default:   logicOut = operandB;
    endcase
  end

  assign result    = strobe.arith ? arithOut[DATA_W-1:0] : logicOut;
  assign nextCarry = strobe.arith & arithOut[DATA_W];
  assign nextZero  = (result == '0);

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags (
  input  logic clk,
  input  logic rstN,
  input  logic flagUpd,
  input  logic nextZero,
  input  logic nextCarry,
  output logic zeroFlag,
  output logic carryFlag
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroFlag  <= 1'b0;
      carryFlag <= 1'b0;
    end else if (flagUpd) begin
      zeroFlag  <= nextZero;
      carryFlag <= nextCarry;
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] constB,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              zeroFlag,
  output logic              carryFlag
);

  alu_strobe_t strobe;
  logic        nextZero;
  logic        nextCarry;

  flag_alu_ctrl ctrl_i (
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  flag_alu_dp #(.DATA_W(DATA_W)) dp_i (
    .strobe    (strobe),
    .regA      (regA),
    .regB      (regB),
    .constB    (constB),
    .carryIn   (carryFlag),
    .result    (result),
    .nextZero  (nextZero),
    .nextCarry (nextCarry)
  );

  flag_alu_flags flags_i (
    .clk       (clk),
    .rstN      (rstN),
    .flagUpd   (strobe.flagUpd),
    .nextZero  (nextZero),
    .nextCarry (nextCarry),
    .zeroFlag  (zeroFlag),
    .carryFlag (carryFlag)
  );

  assign wrEn = strobe.commit;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] result,
  input logic              wrEn,
  input logic              zeroFlag,
  input logic              carryFlag
);

  logic foreignOp;
  logic loadOp;
  logic logicOp;
  logic flagOp;

  assign foreignOp = opCode[2] && opCode[1];
  assign loadOp    = (opCode[2:0] == 3'b011);
  assign logicOp   = !opCode[2] && (opCode[1:0] != 2'b11);
  assign flagOp    = opValid && !foreignOp && !loadOp;

  // R8
  wren_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (opValid && !foreignOp));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(zeroFlag) && $stable(carryFlag)));

  // R6
  load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && loadOp) |=> ($stable(zeroFlag) && $stable(carryFlag)));

  // R8
  foreign_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && foreignOp) |=> ($stable(zeroFlag) && $stable(carryFlag)));

  // R5
  logic_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && logicOp) |=> !carryFlag);

  // R7
  zero_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagOp |=> (zeroFlag == ($past(result) == '0)));

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .result    (result),
  .wrEn      (wrEn),
  .zeroFlag  (zeroFlag),
  .carryFlag (carryFlag)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb_top;

  localparam int W = 8;
  localparam int NVEC = 21;
  localparam int WATCHDOG_NS = 100000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [3:0]   opCode = '0;
  logic [W-1:0] regA = '0;
  logic [W-1:0] regB = '0;
  logic [W-1:0] constB = '0;
  logic [W-1:0] result;
  logic         wrEn;
  logic         zeroFlag;
  logic         carryFlag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flag_alu #(.DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .regA(regA), .regB(regB), .constB(constB),
    .result(result), .wrEn(wrEn), .zeroFlag(zeroFlag), .carryFlag(carryFlag)
  );

  // op, a, regB, constB, expected result, wrEn, zero, carry (flags after the edge)
  localparam logic [38:0] VEC [NVEC] = '{
    {4'b1101, 8'h10, 8'h20, 8'h99, 8'h30, 1'b1, 1'b0, 1'b0},
    {4'b0101, 8'hF0, 8'hEE, 8'h20, 8'h10, 1'b1, 1'b0, 1'b1},
    {4'b0101, 8'h01, 8'hEE, 8'h02, 8'h04, 1'b1, 1'b0, 1'b0},
    {4'b1100, 8'h05, 8'h06, 8'h99, 8'hFF, 1'b1, 1'b0, 1'b1},
    {4'b0100, 8'h05, 8'hEE, 8'h04, 8'h00, 1'b1, 1'b1, 1'b0},
    {4'b1011, 8'h33, 8'h00, 8'h99, 8'h00, 1'b1, 1'b1, 1'b0},
    {4'b1000, 8'h0F, 8'hF0, 8'h99, 8'hFF, 1'b1, 1'b0, 1'b0},
    {4'b1101, 8'hFF, 8'h01, 8'h99, 8'h00, 1'b1, 1'b1, 1'b1},
    {4'b1001, 8'hF0, 8'h0F, 8'h99, 8'h00, 1'b1, 1'b1, 1'b0},
    {4'b1101, 8'h80, 8'h80, 8'h99, 8'h00, 1'b1, 1'b1, 1'b1},
    {4'b1010, 8'hAA, 8'hA5, 8'h99, 8'h0F, 1'b1, 1'b0, 1'b0},
    {4'b0001, 8'h3C, 8'hFF, 8'hF0, 8'h30, 1'b1, 1'b0, 1'b0},
    {4'b0010, 8'h55, 8'hEE, 8'h55, 8'h00, 1'b1, 1'b1, 1'b0},
    {4'b0011, 8'h12, 8'hEE, 8'h7E, 8'h7E, 1'b1, 1'b1, 1'b0},
    {4'b0000, 8'h00, 8'hEE, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0},
    {4'b0110, 8'h12, 8'h34, 8'h56, 8'h00, 1'b0, 1'b1, 1'b0},
    {4'b1101, 8'hFF, 8'hFF, 8'h99, 8'hFE, 1'b1, 1'b0, 1'b1},
    {4'b1100, 8'h10, 8'h0F, 8'h99, 8'h00, 1'b1, 1'b1, 1'b0},
    {4'b1111, 8'h01, 8'h02, 8'h03, 8'h00, 1'b0, 1'b1, 1'b0},
    {4'b0100, 8'h00, 8'hEE, 8'h01, 8'hFF, 1'b1, 1'b0, 1'b1},
    {4'b0000, 8'h80, 8'hEE, 8'h01, 8'h81, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string opTag(input logic [3:0] op);
    if (op[2] && op[1])        return "R8 foreign";
    if (op[2] && op[0])        return "R3 add";
    if (op[2])                 return "R4 sub";
    if (op[1:0] == 2'b11)      return "R6 load";
    return "R5 logic";
  endfunction

  task automatic drive(input logic v, input logic [3:0] op,
                       input logic [W-1:0] a, input logic [W-1:0] rb,
                       input logic [W-1:0] kb);
    @(negedge clk);
    opValid = v; opCode = op; regA = a; regB = rb; constB = kb;
    #1;
  endtask

  initial begin
    #(WATCHDOG_NS);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 zero in reset", int'(zeroFlag), 0);
    check("R1 carry in reset", int'(carryFlag), 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] op;
      logic [W-1:0] expRes;
      logic expWr, expZ, expC;
      op     = VEC[i][38:35];
      expRes = VEC[i][10:3];
      expWr  = VEC[i][2];
      expZ   = VEC[i][1];
      expC   = VEC[i][0];
      drive(1'b1, op, VEC[i][34:27], VEC[i][26:19], VEC[i][18:11]);
      check($sformatf("%s wrEn vec %0d", opTag(op), i), int'(wrEn), int'(expWr));
      if (expWr)
        check($sformatf("%s R2 result vec %0d", opTag(op), i), int'(result), int'(expRes));
      @(posedge clk);
      #1;
      check($sformatf("R7 zero vec %0d", i), int'(zeroFlag), int'(expZ));
      check($sformatf("%s carry vec %0d", opTag(op), i), int'(carryFlag), int'(expC));
    end
    // Flags now z=0 c=0

    // R2: same opcode with swapped sources
    drive(1'b1, 4'b1000, 8'h00, 8'h5A, 8'hA5);
    check("R2 reg source", int'(result), 'h5A);
    drive(1'b1, 4'b0000, 8'h00, 8'h5A, 8'hA5);
    check("R2 const source", int'(result), 'hA5);
    @(posedge clk); #1;  // flags z0 c0

    // Set carry: FF + 01 -> 00 carry 1 zero 1
    drive(1'b1, 4'b1101, 8'hFF, 8'h01, 8'h00);
    // R10: flags have not moved before the edge
    check("R10 carry before edge", int'(carryFlag), 0);
    check("R10 zero before edge", int'(zeroFlag), 0);
    @(posedge clk); #1;
    check("R10 carry after edge", int'(carryFlag), 1);

    // R9: idle with an add presented, no write and flags hold
    drive(1'b0, 4'b1101, 8'h01, 8'h01, 8'h01);
    check("R9 wrEn idle", int'(wrEn), 0);
    @(posedge clk); #1;
    check("R9 carry hold", int'(carryFlag), 1);
    check("R9 zero hold", int'(zeroFlag), 1);

    // R3: carry folded in: 01 + 01 + 1 = 03
    drive(1'b1, 4'b0101, 8'h01, 8'h00, 8'h01);
    check("R3 add with carry-in", int'(result), 3);
    @(posedge clk); #1;
    check("R3 no carry out", int'(carryFlag), 0);

    // R6: load leaves flags after a carry-setting add
    drive(1'b1, 4'b1101, 8'hC0, 8'h40, 8'h00);  // 00, c1 z1
    @(posedge clk); #1;
    drive(1'b1, 4'b1011, 8'h00, 8'h9C, 8'h00);
    check("R6 load result", int'(result), 'h9C);
    @(posedge clk); #1;
    check("R6 load keeps carry", int'(carryFlag), 1);
    check("R6 load keeps zero", int'(zeroFlag), 1);

    // R4: borrow in: 00 - 00 - 1 = FF with borrow
    drive(1'b1, 4'b1100, 8'h00, 8'h00, 8'h00);
    check("R4 sub with borrow-in", int'(result), 'hFF);
    @(posedge clk); #1;
    check("R4 borrow out", int'(carryFlag), 1);

    // R5: OR of a register with itself clears carry
    drive(1'b1, 4'b1000, 8'h21, 8'h21, 8'h00);
    @(posedge clk); #1;
    check("R5 or clears carry", int'(carryFlag), 0);

    // R1: reset mid-run clears flags
    drive(1'b1, 4'b1101, 8'hFF, 8'h01, 8'h00);
    @(posedge clk); #1;
    @(negedge clk);
    opValid = 1'b0;
    rstN = 1'b0;
    @(posedge clk); #1;
    check("R1 zero after reset", int'(zeroFlag), 0);
    check("R1 carry after reset", int'(carryFlag), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule